// File: doc/BRIEF.md
# Bus Transceiver Operating Mode Controller

This synchronous controller chooses the operating mode of a differential bus transceiver. The host selects the mode with two pins: a standby-not pin and an enable pin. Only combinations that stay stable for a filter time are accepted. The controller also listens to three supply under-voltage flags and a wake flag, and these override the mode the pins ask for.

From the mode it drives four things:
- the inhibit output for an external regulator;
- the receiver enable;
- a transmitter enable and bus symbol select, gated by a bus-guardian enable, the active-low transmit enable and a maximum-activation watchdog.

The five states are NORMAL, RXONLY, STANDBY, GOSLEEP and SLEEP. The state register moves on these named transitions:
- **PIN_SELECT**: an accepted pin change maps the new combination to a mode.
- **GTS_EXPIRE**: GOSLEEP goes to SLEEP when the go-to-sleep timer runs out.
- **UV_SLEEP**: a new VBAT or VIO under-voltage forces SLEEP.
- **UV_STANDBY**: a new VCC under-voltage outside SLEEP forces STANDBY.
- **WAKE_STANDBY**: a wake rising edge forces STANDBY.
- **HOLD**: no event, so the mode stays where it is.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: The accepted pin pair {stbn, en} selects the mode as follows: 11 gives NORMAL, 10 gives RXONLY, 00 gives STANDBY and 01 gives GOSLEEP. The mode_o encoding is NORMAL=0, RXONLY=1, STANDBY=2, GOSLEEP=3, SLEEP=4.
- R2: GOSLEEP becomes SLEEP once it has lasted GTS_CYC cycles. If a different pin pair is accepted before then, the mode follows that pair and SLEEP is never reached.
- R3: A new pin pair is accepted only after it has been stable on the synchronized pins for MODE_FILT cycles. Shorter pulses leave the mode unchanged.
- R4: inh_o is 1 (driven) in every mode except SLEEP, where it is 0 (released).
- R5: A rising VBAT or VIO under-voltage flag forces SLEEP. A rising VCC under-voltage flag forces STANDBY, but only when the mode is not SLEEP.
- R6: While any latched under-voltage flag is set, pin changes are ignored. A pin change accepted after all flags have cleared takes effect again.
- R7: A rising wake flag clears all latched under-voltage flags and forces STANDBY. This also holds when an under-voltage flag rises in the same cycle.
- R8: tx_sym_o encodes IDLE_LP=0, IDLE=1, DATA0=2, DATA1=3. It reads:
  - IDLE_LP in STANDBY, GOSLEEP and SLEEP;
  - IDLE in RXONLY;
  - IDLE in NORMAL when bge=0 or txen_n=1;
  - DATA0 or DATA1, following txd, while the transmitter is active.
  Activation starts only in NORMAL and only with txd=0.
- R9: If txen_n stays low in NORMAL for TX_MAX cycles, tx_timeout_o is set and the transmitter returns to idle. The flag clears when txen_n goes high or NORMAL is left.
- R10: rx_en_o is 1 in NORMAL and RXONLY and 0 in every other mode.
- R11: After power-on reset the mode is STANDBY, the transmitter is off and the timeout flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| stbn_i | input | 1 | Host mode pin, standby-not (asynchronous) |
| en_i | input | 1 | Host mode pin, enable (asynchronous) |
| uv_vbat_i | input | 1 | VBAT under-voltage comparator result |
| uv_vcc_i | input | 1 | VCC under-voltage comparator result |
| uv_vio_i | input | 1 | VIO under-voltage comparator result |
| wake_i | input | 1 | Wake flag from the wakeup detectors |
| txen_n_i | input | 1 | Transmit enable, active low (asynchronous) |
| txd_i | input | 1 | Transmit data (asynchronous) |
| bge_i | input | 1 | Bus-guardian enable (asynchronous) |
| mode_o | output | 3 | Current mode (encoding per R1) |
| inh_o | output | 1 | Regulator inhibit: 1 driven, 0 released |
| tx_en_o | output | 1 | Transmitter active |
| tx_sym_o | output | 2 | Bus symbol select (encoding per R8) |
| rx_en_o | output | 1 | Receiver enable |
| tx_timeout_o | output | 1 | Maximum-activation timeout flag |

## Verification
The wake override and an under-voltage override can both fire in the same clock cycle. The bench raises the wake flag and the VIO under-voltage flag on the same clock edge. It expects STANDBY rather than SLEEP, and it then checks that a later pin change is obeyed, which shows the latch was cleared and not left set. A second collision is between the go-to-sleep timer and a pin change. The bench ends the go-to-sleep pin pair before the timer expires and expects the mode to follow the new pair without ever passing through SLEEP.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;
    typedef enum logic [2:0] {
        MD_NORMAL  = 3'd0,
        MD_RXONLY  = 3'd1,
        MD_STANDBY = 3'd2,
        MD_GOSLEEP = 3'd3,
        MD_SLEEP   = 3'd4
    } xm_mode_e;

    typedef enum logic [1:0] {
        SYM_IDLE_LP = 2'd0,
        SYM_IDLE    = 2'd1,
        SYM_DATA0   = 2'd2,
        SYM_DATA1   = 2'd3
    } xm_sym_e;

    localparam int UV_VBAT = 0;
    localparam int UV_VCC  = 1;
    localparam int UV_VIO  = 2;
    localparam int UV_NUM  = 3;
endpackage

// File: rtl/xm_sync.sv
module xm_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/xm_pin_filter.sv
module xm_pin_filter #(
    parameter int W = 2,
    parameter int FILT = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] acc_o,
    output logic         chg_o
);
    localparam int CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] CLAST = CW'(FILT - 1);

    logic [W-1:0]  acc_q;
    logic [W-1:0]  last_q;
    logic [CW-1:0] cnt_q;
    logic          chg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= RST_VAL;
            last_q <= RST_VAL;
            cnt_q  <= '0;
            chg_q  <= 1'b0;
        end else begin
            last_q <= din_i;
            chg_q  <= 1'b0;
            if (din_i == acc_q || din_i != last_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CLAST) begin
                acc_q <= din_i;
                chg_q <= 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign acc_o = acc_q;
    assign chg_o = chg_q;

    // R3: an accepted pair must have been on the input in the previous cycle
    a_r3_accept_stable: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q |-> (acc_q == $past(din_i)));
endmodule

// File: rtl/xm_tx_gate.sv
module xm_tx_gate
    import xcvr_mode_pkg::*;
#(
    parameter int TX_MAX = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  xm_mode_e  mode_i,
    input  logic      bge_i,
    input  logic      txen_n_i,
    input  logic      txd_i,
    output logic      tx_en_o,
    output logic [1:0] sym_o,
    output logic      timeout_o
);
    localparam int TW = $clog2(TX_MAX + 1);
    localparam logic [TW-1:0] TLAST = TW'(TX_MAX - 1);

    logic [TW-1:0] act_cnt_q;
    logic          to_q;
    logic          act_q;
    logic          is_normal;
    logic          low_power;
    logic          tx_go;

    assign is_normal = (mode_i == MD_NORMAL);
    assign low_power = (mode_i == MD_STANDBY) || (mode_i == MD_GOSLEEP) || (mode_i == MD_SLEEP);
    assign tx_go     = is_normal && bge_i && !txen_n_i && !to_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cnt_q <= '0;
            to_q      <= 1'b0;
        end else if (!is_normal || txen_n_i) begin
            act_cnt_q <= '0;
            to_q      <= 1'b0;
        end else if (act_cnt_q == TLAST) begin
            to_q      <= 1'b1;
        end else begin
            act_cnt_q <= act_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (!tx_go) begin
            act_q <= 1'b0;
        end else if (!act_q && !txd_i) begin
            act_q <= 1'b1;
        end
    end

    always_comb begin
        if (act_q)          sym_o = txd_i ? SYM_DATA1 : SYM_DATA0;
        else if (low_power) sym_o = SYM_IDLE_LP;
        else                sym_o = SYM_IDLE;
    end

    assign tx_en_o   = act_q;
    assign timeout_o = to_q;

    // R8: activation begins only in NORMAL and only on a zero bit
    a_r8_start_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> ($past(mode_i) == MD_NORMAL && !$past(txd_i)));
    // R9: a high transmit-enable clears the timeout on the next edge
    a_r9_timeout_clear: assert property (@(posedge clk) disable iff (!rst_n)
        txen_n_i |=> !to_q);
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int MODE_FILT = 2000,
    parameter int GTS_CYC   = 4000,
    parameter int TX_MAX    = 75000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stbn_i,
    input  logic       en_i,
    input  logic       uv_vbat_i,
    input  logic       uv_vcc_i,
    input  logic       uv_vio_i,
    input  logic       wake_i,
    input  logic       txen_n_i,
    input  logic       txd_i,
    input  logic       bge_i,
    output logic [2:0] mode_o,
    output logic       inh_o,
    output logic       tx_en_o,
    output logic [1:0] tx_sym_o,
    output logic       rx_en_o,
    output logic       tx_timeout_o
);
    localparam int GW = $clog2(GTS_CYC + 1);
    localparam logic [GW-1:0] GLAST = GW'(GTS_CYC - 1);

    logic [4:0] sync_s;
    logic       stbn_s, en_s, txen_n_s, bge_s, txd_s;
    logic [1:0] pins_acc;
    logic       pins_chg;

    xm_sync #(.W(5), .RST_VAL(5'b00100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({stbn_i, en_i, txen_n_i, bge_i, txd_i}),
        .q_o(sync_s)
    );
    assign {stbn_s, en_s, txen_n_s, bge_s, txd_s} = sync_s;

    xm_pin_filter #(.W(2), .FILT(MODE_FILT), .RST_VAL(2'b00)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .din_i({stbn_s, en_s}),
        .acc_o(pins_acc), .chg_o(pins_chg)
    );

    // supply flag latches and wake edge
    logic [UV_NUM-1:0] uv_in, uv_prev_q, uv_q, uv_rise;
    logic              wake_prev_q, wake_rise, uv_any_q;

    assign uv_in     = {uv_vio_i, uv_vcc_i, uv_vbat_i};
    assign uv_rise   = uv_in & ~uv_prev_q;
    assign wake_rise = wake_i & ~wake_prev_q;
    assign uv_any_q  = |uv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_prev_q   <= '0;
            uv_q        <= '0;
            wake_prev_q <= 1'b0;
        end else begin
            uv_prev_q   <= uv_in;
            wake_prev_q <= wake_i;
            if (wake_rise) uv_q <= '0;
            else           uv_q <= (uv_q | uv_rise) & uv_in;
        end
    end

    // mode state machine
    xm_mode_e      state_q, state_d;
    logic [GW-1:0] gts_cnt_q;
    logic          gts_done;

    assign gts_done = (state_q == MD_GOSLEEP) && (gts_cnt_q == GLAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     gts_cnt_q <= '0;
        else if (state_q != MD_GOSLEEP) gts_cnt_q <= '0;
        else if (!gts_done)             gts_cnt_q <= gts_cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (wake_rise) begin
            state_d = MD_STANDBY;
        end else if (uv_rise[UV_VBAT] || uv_rise[UV_VIO]) begin
            state_d = MD_SLEEP;
        end else if (uv_rise[UV_VCC] && state_q != MD_SLEEP) begin
            state_d = MD_STANDBY;
        end else if (uv_any_q || (|uv_rise)) begin
            state_d = state_q;
        end else if (pins_chg) begin
            unique case (pins_acc)
                2'b11: state_d = MD_NORMAL;
                2'b10: state_d = MD_RXONLY;
                2'b00: state_d = MD_STANDBY;
                2'b01: state_d = MD_GOSLEEP;
                default: state_d = state_q;
            endcase
        end else if (gts_done) begin
            state_d = MD_SLEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MD_STANDBY;
        else        state_q <= state_d;
    end

    // mode-derived outputs
    always_comb begin
        inh_o   = 1'b1;
        rx_en_o = 1'b0;
        unique case (state_q)
            MD_NORMAL, MD_RXONLY: rx_en_o = 1'b1;
            MD_STANDBY, MD_GOSLEEP: rx_en_o = 1'b0;
            MD_SLEEP: inh_o = 1'b0;
            default: inh_o = 1'b1;
        endcase
    end
    assign mode_o = state_q;

    xm_tx_gate #(.TX_MAX(TX_MAX)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .mode_i(state_q), .bge_i(bge_s), .txen_n_i(txen_n_s), .txd_i(txd_s),
        .tx_en_o(tx_en_o), .sym_o(tx_sym_o), .timeout_o(tx_timeout_o)
    );

    // R2/R5: SLEEP is entered only from GOSLEEP or on a VBAT/VIO flag rise
    a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MD_SLEEP && $past(state_q) != MD_SLEEP) |->
        ($past(state_q) == MD_GOSLEEP || $past(uv_rise[UV_VBAT]) || $past(uv_rise[UV_VIO])));
    // R6: a latched supply flag keeps the block in a low-power mode
    a_r6_uv_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        uv_any_q |-> (state_q == MD_STANDBY || state_q == MD_SLEEP));
    // R7: a wake edge always lands in STANDBY with no flag latched
    a_r7_wake_standby: assert property (@(posedge clk) disable iff (!rst_n)
        wake_rise |=> (state_q == MD_STANDBY && !uv_any_q));
endmodule

// File: tb/xcvr_mode_ctrl_test.sv
module xcvr_mode_ctrl_test;
    localparam int FILT = 8;
    localparam int GTS  = 40;
    localparam int TXM  = 60;

    localparam logic [2:0] M_NORM = 3'd0, M_RX = 3'd1, M_STBY = 3'd2, M_GTS = 3'd3, M_SLP = 3'd4;
    localparam logic [1:0] S_LP = 2'd0, S_ID = 2'd1, S_D0 = 2'd2, S_D1 = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stbn = 1'b0, en = 1'b0, uv_vbat = 1'b0, uv_vcc = 1'b0, uv_vio = 1'b0, wake = 1'b0;
    logic txen_n = 1'b1, txd = 1'b0, bge = 1'b0;
    logic [2:0] mode;
    logic [1:0] sym;
    logic inh, tx_en, rx_en, tout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xcvr_mode_ctrl #(.MODE_FILT(FILT), .GTS_CYC(GTS), .TX_MAX(TXM)) uut (
        .clk(clk), .rst_n(rst_n), .stbn_i(stbn), .en_i(en),
        .uv_vbat_i(uv_vbat), .uv_vcc_i(uv_vcc), .uv_vio_i(uv_vio), .wake_i(wake),
        .txen_n_i(txen_n), .txd_i(txd), .bge_i(bge),
        .mode_o(mode), .inh_o(inh), .tx_en_o(tx_en), .tx_sym_o(sym),
        .rx_en_o(rx_en), .tx_timeout_o(tout)
    );

    // {stbn,en,bge,txen_n,txd, mode, sym, tx_en, rx_en, inh}
    localparam int NV = 8;
    localparam logic [12:0] VEC [NV] = '{
        {2'b11, 1'b1, 1'b1, 1'b0, M_NORM, S_ID, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b0, M_NORM, S_D0, 1'b1, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b1, M_NORM, S_D1, 1'b1, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b1, 1'b1, M_NORM, S_ID, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b0, 1'b1, M_NORM, S_ID, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b0, 1'b0, M_RX,   S_ID, 1'b0, 1'b1, 1'b1},
        {2'b00, 1'b1, 1'b1, 1'b0, M_STBY, S_LP, 1'b0, 1'b0, 1'b1},
        {2'b11, 1'b1, 1'b1, 1'b0, M_NORM, S_ID, 1'b0, 1'b1, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic pins(input logic s, input logic e);
        stbn = s;
        en = e;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R11 reset state
        chk("R11", "mode", mode, M_STBY);
        chk("R11", "tx_en", tx_en, 0);
        chk("R11", "timeout", tout, 0);
        chk("R10", "rx_en in standby", rx_en, 0);
        chk("R4", "inh in standby", inh, 1);

        // vector table: R1, R8, R10, R4
        for (int i = 0; i < NV; i++) begin
            {stbn, en, bge, txen_n, txd} = VEC[i][12:8];
            step(20);
            chk("R1", $sformatf("vec%0d mode", i), mode, int'(VEC[i][7:5]));
            chk("R8", $sformatf("vec%0d sym", i), sym, int'(VEC[i][4:3]));
            chk("R8", $sformatf("vec%0d tx_en", i), tx_en, int'(VEC[i][2]));
            chk("R10", $sformatf("vec%0d rx_en", i), rx_en, int'(VEC[i][1]));
            chk("R4", $sformatf("vec%0d inh", i), inh, int'(VEC[i][0]));
        end

        // R3 short glitch ignored
        pins(1'b0, 1'b0);
        step(4);
        pins(1'b1, 1'b1);
        step(20);
        chk("R3", "glitch ignored", mode, M_NORM);

        // R2 short go-to-sleep returns to NORMAL
        pins(1'b0, 1'b1);
        step(14);
        chk("R2", "gosleep entered", mode, M_GTS);
        chk("R4", "inh in gosleep", inh, 1);
        step(6);
        pins(1'b1, 1'b1);
        step(20);
        chk("R2", "short gosleep back to normal", mode, M_NORM);

        // R2 long go-to-sleep reaches SLEEP
        pins(1'b0, 1'b1);
        step(70);
        chk("R2", "timeout to sleep", mode, M_SLP);
        chk("R4", "inh released in sleep", inh, 0);
        chk("R10", "rx off in sleep", rx_en, 0);
        chk("R8", "sym in sleep", sym, S_LP);
        pins(1'b1, 1'b1);
        step(20);
        chk("R1", "sleep to normal by pins", mode, M_NORM);

        // R5/R6 VCC under-voltage
        uv_vcc = 1'b1;
        step(3);
        chk("R5", "vcc uv forces standby", mode, M_STBY);
        pins(1'b1, 1'b0);
        step(20);
        chk("R6", "pins ignored during uv", mode, M_STBY);
        uv_vcc = 1'b0;
        step(2);
        pins(1'b1, 1'b1);
        step(20);
        chk("R6", "pins obeyed after uv clears", mode, M_NORM);

        // R5 VBAT forces sleep; VCC rise in sleep keeps sleep
        uv_vbat = 1'b1;
        step(3);
        chk("R5", "vbat uv forces sleep", mode, M_SLP);
        uv_vcc = 1'b1;
        step(3);
        chk("R5", "vcc uv in sleep stays sleep", mode, M_SLP);
        uv_vcc = 1'b0;
        step(2);

        // R7 wake clears flags and forces standby
        wake = 1'b1;
        step(3);
        chk("R7", "wake forces standby", mode, M_STBY);
        pins(1'b1, 1'b0);
        step(20);
        chk("R7", "flags cleared by wake", mode, M_RX);
        wake = 1'b0;
        uv_vbat = 1'b0;
        step(2);

        // R7 wake and VIO uv in the same cycle
        pins(1'b1, 1'b1);
        step(20);
        chk("R1", "normal before collision", mode, M_NORM);
        wake = 1'b1;
        uv_vio = 1'b1;
        step(3);
        chk("R7", "wake wins over vio uv", mode, M_STBY);
        pins(1'b1, 1'b0);
        step(20);
        chk("R7", "vio flag not latched", mode, M_RX);
        wake = 1'b0;
        uv_vio = 1'b0;

        // R9 activation timeout
        pins(1'b1, 1'b1);
        bge = 1'b1;
        txd = 1'b0;
        txen_n = 1'b1;
        step(20);
        txen_n = 1'b0;
        step(10);
        chk("R8", "active before timeout", tx_en, 1);
        chk("R8", "data0 before timeout", sym, S_D0);
        step(70);
        chk("R9", "timeout set", tout, 1);
        chk("R9", "tx off on timeout", tx_en, 0);
        chk("R9", "idle on timeout", sym, S_ID);
        txen_n = 1'b1;
        step(5);
        chk("R9", "timeout cleared by txen high", tout, 0);
        txen_n = 1'b0;
        step(75);
        chk("R9", "timeout set again", tout, 1);
        pins(1'b1, 1'b0);
        step(20);
        chk("R9", "timeout cleared leaving normal", tout, 0);
        chk("R10", "rx on in rxonly", rx_en, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule